// File: doc/BRIEF.md
# Fractional PLL Reprogramming Sequencer

This block changes the output frequency of a fractional PLL without letting the oscillator run on a half-written configuration. A single-cycle start pulse delivers a new 12-bit feedback divider and a 24-bit fraction. The sequencer then issues five writes, one per cycle, on a one-port write bus to three 32-bit control words. The first write turns the PLL off. The next three load the divider, the fraction and the two post-dividers. The last write turns the PLL on again.

Every write is a read-modify-write. The block reads the current contents of the three words on its read inputs and changes only the fields it owns. After the enable write it samples a lock status word once per poll step of about 1 µs. It stops at the first sample in which any bit of the configured lock field is set, or after about 100 µs with no such sample.

Computing the divider values is done elsewhere, and the analog PLL is not part of the block. The outcome is a one-cycle done pulse or a one-cycle lock-failure pulse.

Top module: `pll_reprog_seq`

## Requirements
- R1: After start, the first write goes to control word 0 (`wr_sel_o` = 0). It carries that word's current value with the enable field [1:0] cleared to 0. Control words 1 and 2 are only written while the enable field of word 0 reads 0.
- R2: The second write goes to word 0. It places the held feedback divider in [31:20] and the value 1 in [17:12], and keeps [1:0] at 0. All other bits keep their current value.
- R3: The third write goes to word 1 (`wr_sel_o` = 1). It places the held fraction in [27:4] and leaves every other bit unchanged.
- R4: The fourth write goes to word 2 (`wr_sel_o` = 2). It places the value 1 in both [10:8] and [18:16] and leaves every other bit unchanged.
- R5: The fifth and final write goes to word 0. It sets [1:0] to 01 and leaves every other bit unchanged. Exactly five writes are issued per sequence, in the order 0, 0, 1, 2, 0.
- R6: The lock status is sampled once every POLL_CYC = CLK_MHZ*POLL_US cycles after the enable write. Sample k is taken in the cycle before the k-th POLL_CYC-th edge after the edge that registers the enable write. If any bit of `lock_stat_i[LOCK_SHIFT +: LOCK_WIDTH]` is set at that sample, `done_o` rises right after that edge. Status bits outside the field have no effect.
- R7: If none of the first MAX_POLLS = TIMEOUT_US/POLL_US samples finds lock, `err_o` pulses after the last one. Word 0 is then left enabled (01) with the new fields in place.
- R8: `busy_o` is high from the edge that accepts start until the edge that raises done or error. A start pulse while busy is ignored: it changes neither the held values nor the number of writes.
- R9: `done_o` and `err_o` are each one cycle wide, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; inputs below captured with it |
| fbdiv_i | input | 12 | New feedback divider |
| frac_i | input | 24 | New 24-bit fraction |
| ctrl0_rd_i | input | 32 | Current contents of control word 0 |
| ctrl1_rd_i | input | 32 | Current contents of control word 1 |
| ctrl2_rd_i | input | 32 | Current contents of control word 2 |
| lock_stat_i | input | 32 | PLL status word containing the lock field |
| wr_en_o | output | 1 | Write strobe, one cycle per write |
| wr_sel_o | output | 2 | Target word: 0, 1 or 2 |
| wr_data_o | output | 32 | Full 32-bit value to write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: lock seen |
| err_o | output | 1 | One-cycle pulse: lock timeout |

## Verification
The lock delay is swept from zero cycles to past the timeout window. The lit lock bit rotates across every position of the field, while bits outside the field are held high. This separates a sample taken one step early or late from a correct one, and an off-by-one in the poll count from a correct timeout. Every sequence starts from different background contents in the three words. A field mask that is too wide or too narrow, or a bit that is lost, shows up in the final register values. A second start issued mid-sequence with different divider values shows whether the values held at the first start are kept.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DIS, ST_DIV, ST_FRAC, ST_POST, ST_EN, ST_WAIT
    } seq_st_e;

    localparam int FBDIV_W    = 12;
    localparam int FRAC_W     = 24;
    localparam int EN_LSB     = 0;
    localparam int EN_W       = 2;
    localparam int REFDIV_LSB = 12;
    localparam int REFDIV_W   = 6;
    localparam int FBDIV_LSB  = 20;
    localparam int FRAC_LSB   = 4;
    localparam int PD1_LSB    = 8;
    localparam int PD2_LSB    = 16;
    localparam int PD_W       = 3;

    localparam logic [1:0] SEL_W0 = 2'd0;
    localparam logic [1:0] SEL_W1 = 2'd1;
    localparam logic [1:0] SEL_W2 = 2'd2;

    function automatic logic [31:0] put_field(input logic [31:0] word,
                                              input int lsb, input int width,
                                              input logic [31:0] val);
        logic [31:0] mask;
        mask = ((32'h1 << width) - 32'h1) << lsb;
        return (word & ~mask) | ((val << lsb) & mask);
    endfunction

endpackage

// File: rtl/pll_field_merge.sv
module pll_field_merge
    import pll_seq_pkg::*;
(
    input  seq_st_e              st_i,
    input  logic [FBDIV_W-1:0]   fbdiv_i,
    input  logic [FRAC_W-1:0]    frac_i,
    input  logic [31:0]          w0_i,
    input  logic [31:0]          w1_i,
    input  logic [31:0]          w2_i,
    output logic                 wr_en_o,
    output logic [1:0]           wr_sel_o,
    output logic [31:0]          wr_data_o
);
    logic [31:0] tmp;

    always_comb begin
        wr_en_o   = 1'b1;
        wr_sel_o  = SEL_W0;
        wr_data_o = w0_i;
        tmp       = w0_i;
        case (st_i)
            ST_DIS: begin
                wr_data_o = put_field(w0_i, EN_LSB, EN_W, 32'd0);
            end
            ST_DIV: begin
                tmp       = put_field(w0_i, FBDIV_LSB, FBDIV_W, 32'(fbdiv_i));
                tmp       = put_field(tmp, REFDIV_LSB, REFDIV_W, 32'd1);
                wr_data_o = put_field(tmp, EN_LSB, EN_W, 32'd0);
            end
            ST_FRAC: begin
                wr_sel_o  = SEL_W1;
                wr_data_o = put_field(w1_i, FRAC_LSB, FRAC_W, 32'(frac_i));
            end
            ST_POST: begin
                wr_sel_o  = SEL_W2;
                tmp       = put_field(w2_i, PD1_LSB, PD_W, 32'd1);
                wr_data_o = put_field(tmp, PD2_LSB, PD_W, 32'd1);
            end
            ST_EN: begin
                wr_data_o = put_field(w0_i, EN_LSB, EN_W, 32'd1);
            end
            default: begin
                wr_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pll_lock_poll.sv
module pll_lock_poll #(
    parameter int POLL_CYC   = 50,
    parameter int MAX_POLLS  = 100,
    parameter int LOCK_SHIFT = 0,
    parameter int LOCK_WIDTH = 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        arm_i,
    input  logic [31:0] stat_i,
    output logic        hit_o,
    output logic        miss_o
);
    localparam int CW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [31:0] LOCK_MASK =
        ((32'h1 << LOCK_WIDTH) - 32'h1) << LOCK_SHIFT;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic [PW-1:0] polls;
    } poll_s;

    poll_s q, d;
    logic  locked;

    assign locked = |(stat_i & LOCK_MASK);

    always_comb begin
        d      = q;
        hit_o  = 1'b0;
        miss_o = 1'b0;
        if (arm_i) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.polls  = '0;
        end else if (q.active) begin
            if (q.cnt == CW'(POLL_CYC - 1)) begin
                d.cnt = '0;
                if (locked) begin
                    hit_o    = 1'b1;
                    d.active = 1'b0;
                end else if (q.polls == PW'(MAX_POLLS - 1)) begin
                    miss_o   = 1'b1;
                    d.active = 1'b0;
                end else begin
                    d.polls = q.polls + 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // R7: the poll count never runs past the timeout budget
    a_r7_polls_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.active |-> (int'(q.polls) < MAX_POLLS));
    // R6: a sample gives exactly one verdict
    a_r6_single_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_o && miss_o));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int POLL_US    = 1,
    parameter int TIMEOUT_US = 100,
    parameter int LOCK_SHIFT = 0,
    parameter int LOCK_WIDTH = 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic [11:0] fbdiv_i,
    input  logic [23:0] frac_i,
    input  logic [31:0] ctrl0_rd_i,
    input  logic [31:0] ctrl1_rd_i,
    input  logic [31:0] ctrl2_rd_i,
    input  logic [31:0] lock_stat_i,
    output logic        wr_en_o,
    output logic [1:0]  wr_sel_o,
    output logic [31:0] wr_data_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o
);
    localparam int POLL_CYC  = CLK_MHZ * POLL_US;
    localparam int MAX_POLLS = TIMEOUT_US / POLL_US;

    typedef struct packed {
        seq_st_e            st;
        logic [FBDIV_W-1:0] fb;
        logic [FRAC_W-1:0]  fr;
        logic               done;
        logic               err;
    } seq_s;

    seq_s q, d;
    logic hit, miss, arm;

    assign arm = (q.st == ST_EN);

    pll_field_merge u_merge (
        .st_i     (q.st),
        .fbdiv_i  (q.fb),
        .frac_i   (q.fr),
        .w0_i     (ctrl0_rd_i),
        .w1_i     (ctrl1_rd_i),
        .w2_i     (ctrl2_rd_i),
        .wr_en_o  (wr_en_o),
        .wr_sel_o (wr_sel_o),
        .wr_data_o(wr_data_o)
    );

    pll_lock_poll #(
        .POLL_CYC  (POLL_CYC),
        .MAX_POLLS (MAX_POLLS),
        .LOCK_SHIFT(LOCK_SHIFT),
        .LOCK_WIDTH(LOCK_WIDTH)
    ) u_poll (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .arm_i (arm),
        .stat_i(lock_stat_i),
        .hit_o (hit),
        .miss_o(miss)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: if (start_i) begin
                d.fb = fbdiv_i;
                d.fr = frac_i;
                d.st = ST_DIS;
            end
            ST_DIS:  d.st = ST_DIV;
            ST_DIV:  d.st = ST_FRAC;
            ST_FRAC: d.st = ST_POST;
            ST_POST: d.st = ST_EN;
            ST_EN:   d.st = ST_WAIT;
            ST_WAIT: begin
                if (hit) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else if (miss) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: ST_IDLE, default: '0};
        else         q <= d;
    end

    assign busy_o = (q.st != ST_IDLE);
    assign done_o = q.done;
    assign err_o  = q.err;

    // R9: outcome pulses are single-cycle and exclusive
    a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    a_r9_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o);
    a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o));
    // R1: words 1 and 2 are only written while the PLL reads disabled
    a_r1_disabled_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && wr_sel_o != SEL_W0) |-> (ctrl0_rd_i[1:0] == 2'b00));
    // R8: a sequence only begins on a start pulse
    a_r8_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));
    // R7: a timeout leaves the PLL enabled
    a_r7_err_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (ctrl0_rd_i[1:0] == 2'b01));

endmodule

// File: tb/pll_reprog_seq_bench.sv
`timescale 1ns/1ps
module pll_reprog_seq_bench;
    localparam int CLK_MHZ = 3, POLL_US = 1, TIMEOUT_US = 6;
    localparam int LSH = 4, LW = 3;
    localparam int P = CLK_MHZ * POLL_US;
    localparam int N = TIMEOUT_US / POLL_US;

    logic clk = 0, rst_n = 0, start = 0;
    logic [11:0] fb = 0;
    logic [23:0] fr = 0;
    logic [31:0] r0, r1, r2, stat;
    logic wr_en, busy, done, err;
    logic [1:0] wr_sel;
    logic [31:0] wr_data;

    int checks = 0, failures = 0, cyc = 0;
    logic load_req = 0;
    logic [31:0] i0, i1, i2;
    int wcount, since_en, lock_lat = 0, bsel = 0;
    logic en_seen;
    logic [1:0]  log_sel [8];
    logic [31:0] log_dat [8];
    logic lock;

    always #10 clk = ~clk;

    pll_reprog_seq #(.CLK_MHZ(CLK_MHZ), .POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US),
                     .LOCK_SHIFT(LSH), .LOCK_WIDTH(LW)) u_pll_reprog_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fbdiv_i(fb), .frac_i(fr),
        .ctrl0_rd_i(r0), .ctrl1_rd_i(r1), .ctrl2_rd_i(r2), .lock_stat_i(stat),
        .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
        .busy_o(busy), .done_o(done), .err_o(err));

    // register file and behavioural lock model
    assign lock = en_seen && (since_en >= lock_lat);
    assign stat = 32'h8000_000B | (lock ? (32'h1 << (LSH + bsel)) : 32'h0);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (load_req) begin
            r0 <= i0; r1 <= i1; r2 <= i2;
            wcount <= 0; en_seen <= 0; since_en <= 0;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    2'd0: r0 <= wr_data;
                    2'd1: r1 <= wr_data;
                    default: r2 <= wr_data;
                endcase
                if (wcount < 8) begin
                    log_sel[wcount] <= wr_sel;
                    log_dat[wcount] <= wr_data;
                end
                wcount <= wcount + 1;
                if (wr_sel == 2'd0 && wr_data[1:0] == 2'b01) begin
                    en_seen <= 1; since_en <= 0;
                end
            end else if (en_seen) since_en <= since_en + 1;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        @(negedge clk);
        i0 = a; i1 = b; i2 = c; load_req = 1;
        @(negedge clk);
        load_req = 0;
    endtask

    task automatic run_case(input int lat, input int bs, input bit restart);
        logic [31:0] a, b, c, e0, e1, e2;
        logic [11:0] f; logic [23:0] x;
        int k, guard, exp_t;
        bit exp_done;
        a = 32'hA5C3_96F0 ^ (32'h0101_0101 * lat);
        b = 32'h5A3C_690F ^ (32'h0F00_F00F * lat);
        c = ~a;
        f = 12'(lat * 173 + 5);
        x = 24'(lat * 24'h1357B + 24'hF00001);
        lock_lat = lat; bsel = bs;
        preload(a, b, c);
        fb = f; fr = x; start = 1;
        @(negedge clk);
        start = 0;
        check(busy == 1, "R8 busy after start", 32'(busy), 1);
        if (restart) begin
            @(negedge clk);
            fb = ~f; fr = ~x; start = 1;
            @(negedge clk);
            start = 0; fb = 0; fr = 0;
        end
        guard = 0;
        while (!(done || err) && guard < 200) begin
            @(negedge clk); guard++;
        end
        k = (lat + P) / P;
        exp_done = (k <= N);
        exp_t = exp_done ? k * P : N * P;
        check(done == exp_done && err == !exp_done, "R6/R7 outcome",
              {30'd0, err, done}, {30'd0, !exp_done, exp_done});
        if (exp_done) check(since_en == exp_t, "R6 lock sample timing", since_en, exp_t);
        else          check(since_en == exp_t, "R7 timeout timing", since_en, exp_t);
        check(busy == 0, "R8 busy low at outcome", 32'(busy), 0);
        e0 = (a & ~32'hFFF3_F003) | (32'(f) << 20) | (32'h1 << 12) | 32'h1;
        e1 = (b & ~32'h0FFF_FFF0) | (32'(x) << 4);
        e2 = (c & ~32'h0007_0700) | 32'h0001_0100;
        check(wcount == 5, "R5 write count", wcount, 5);
        check(log_sel[0] == 0 && log_dat[0] == (a & ~32'h3), "R1 disable write",
              log_dat[0], a & ~32'h3);
        check(log_sel[1] == 0 && log_dat[1] == (e0 & ~32'h3), "R2 divider write",
              log_dat[1], e0 & ~32'h3);
        check(log_sel[2] == 1 && r1 == e1, "R3 fraction word", r1, e1);
        check(log_sel[3] == 2 && r2 == e2, "R4 post-divider word", r2, e2);
        check(log_sel[4] == 0 && r0 == e0, "R5 final enable word", r0, e0);
        if (!exp_done) check(r0[1:0] == 2'b01, "R7 left enabled", 32'(r0[1:0]), 1);
        @(negedge clk);
        check(done == 0 && err == 0, "R9 single-cycle pulse", {30'd0, err, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && err == 0 && wr_en == 0, "R8 reset state",
              {28'd0, wr_en, busy, err, done}, 0);
        rst_n = 1;
        for (int lat = 0; lat <= N * P + 2; lat++) run_case(lat, lat % LW, 1'b0);
        run_case(4, 1, 1'b1);   // R8 start ignored while busy
        run_case(0, 2, 1'b1);   // R8 start ignored while busy
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc == 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule